// File: doc/BRIEF.md
# Max-Log Soft Bit LLR Unit

This block turns a full set of per-point distance metrics for one transmit antenna of a 16-QAM spatial-multiplexing receiver into four soft bit values. Each cycle it may accept a vector of 16 unsigned metrics, one for every constellation label. For each bit of the 4-bit label it searches the smallest metric among the labels that carry a 0 in that bit and the smallest among those that carry a 1. The signed difference of the two minima is the max-log likelihood ratio, which is then scaled down and clipped to a signed 8-bit value for the channel decoder.

Because every label has a metric, both hypotheses exist for every bit and no fallback value is ever needed. Labels follow Gray mapping with bits 3:2 choosing the in-phase level and bits 1:0 the quadrature level. The metric for label `i` sits in lane `i` of the input, so the bit partition depends only on the label value. The scale step is chosen at build time. One variant is a cheap arithmetic right shift by a per-vector amount, which suits decoders that are linear in their inputs. The other is a small multiply by a fixed-point factor.

The unit is fully pipelined. It takes a new vector every cycle and returns the four results exactly two cycles later, together with a matching valid flag.

Top module: `llr_unit`

## Requirements
- R1: `outValid` is 0 while reset is held, and otherwise equals `inValid` from two rising edges earlier. A vector presented with `inValid` high yields its result in the cycle its `outValid` is high.
- R2: For bit `b` (0..3), the unit uses `min0`, the smallest metric over labels `i` with bit `b` of `i` equal to 0, and `min1`, the smallest over labels with that bit equal to 1. The metric for label `i` is `metricsIn[10*i +: 10]`.
- R3: The unscaled result is `min1 - min0`, so a positive value favours a 0 bit. When all 16 metrics are equal, every lane is 0.
- R4: With `USE_MULT = 0`, the unscaled value is arithmetically shifted right by `scaleSel` (rounding toward minus infinity). `scaleSel` is captured together with the same vector. A shift larger than 10 leaves only 0 or -1.
- R5: The scaled value saturates to the range -128..127.
- R6: Vectors presented on consecutive cycles produce results on consecutive cycles, with no bubble.
- R7: The result for bit `b` is `llrOut[8*b +: 8]`, in two's complement.
- R8: With `USE_MULT = 1`, the unscaled value is multiplied by `scaleSel` as an unsigned factor with 2 fraction bits. The product is shifted right arithmetically by 2, then saturated as in R5.
- R9: `llrOut` is 0 after reset and holds its last result in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A metric vector is present this cycle |
| metricsIn | input | 160 | 16 unsigned 10-bit metrics; label `i` in bits `10*i +: 10` |
| scaleSel | input | 4 | Shift amount (shift variant) or Q2.2 factor (multiply variant) |
| outValid | output | 1 | `llrOut` carries a new result |
| llrOut | output | 32 | Four signed 8-bit results; bit `b` in bits `8*b +: 8` |

## Verification
Every cycle, the assertions check four things. The valid flag is a two-cycle delay of the input strobe. The results stay frozen while no result is flagged. A vector of equal metrics gives all-zero lanes. An over-long shift collapses each lane to 0 or -1. The bench's scenarios must show the remaining behaviours: the bit-partition minimum search, the sign convention, floor rounding of negative values, saturation at both rails and the multiply variant. It compares arithmetic reference values against single-point-hot vectors, equal vectors, swept scales, random streams with and without bubbles, and both build variants.

// File: rtl/llr_pkg.sv
package llr_pkg;
  // Strobes from control to datapath: capture stage-1 minima, capture stage-2 result.
  typedef struct packed {
    logic capMin;
    logic capOut;
  } llrStrobes_t;
endpackage

// File: rtl/llr_ctrl.sv
module llr_ctrl
  import llr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output llrStrobes_t strobes,
  output logic        outValid
);
  logic midValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  always_comb begin
    strobes.capMin = inValid;
    strobes.capOut = midValid;
  end
endmodule

// File: rtl/llr_datapath.sv
module llr_datapath
  import llr_pkg::*;
#(
  parameter int METRIC_W = 10,
  parameter int SYM_BITS = 4,
  parameter int LLR_W    = 8,
  parameter int SCALE_W  = 4,
  parameter int FRAC_W   = 2,
  parameter bit USE_MULT = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  llrStrobes_t                   strobes,
  input  logic [(1<<SYM_BITS)*METRIC_W-1:0] metricsIn,
  input  logic [SCALE_W-1:0]            scaleSel,
  output logic [SYM_BITS*LLR_W-1:0]     llrOut
);
  localparam int NUM_PTS = 1 << SYM_BITS;
  localparam int DIFF_W  = METRIC_W + 1;
  localparam int WIDE_W  = DIFF_W + SCALE_W + 1;
  localparam logic signed [WIDE_W-1:0] SAT_HI = WIDE_W'((2 ** (LLR_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] SAT_LO = -SAT_HI - WIDE_W'(1);

  logic [METRIC_W-1:0] min0Comb [SYM_BITS];
  logic [METRIC_W-1:0] min1Comb [SYM_BITS];
  logic [METRIC_W-1:0] min0Q    [SYM_BITS];
  logic [METRIC_W-1:0] min1Q    [SYM_BITS];
  logic [SCALE_W-1:0]  scaleQ;

  // Stage 1: per-bit minimum over each half of the label set.
  always_comb begin
    for (int b = 0; b < SYM_BITS; b++) begin
      min0Comb[b] = '1;
      min1Comb[b] = '1;
      for (int p = 0; p < NUM_PTS; p++) begin
        logic [METRIC_W-1:0] m;
        m = metricsIn[p*METRIC_W +: METRIC_W];
        if (p[b]) begin
          if (m < min1Comb[b]) min1Comb[b] = m;
        end else begin
          if (m < min0Comb[b]) min0Comb[b] = m;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaleQ <= '0;
      for (int b = 0; b < SYM_BITS; b++) begin
        min0Q[b] <= '0;
        min1Q[b] <= '0;
      end
    end else if (strobes.capMin) begin
      scaleQ <= scaleSel;
      for (int b = 0; b < SYM_BITS; b++) begin
        min0Q[b] <= min0Comb[b];
        min1Q[b] <= min1Comb[b];
      end
    end
  end

  // Stage 2: difference, scaling variant, saturation.
  for (genvar b = 0; b < SYM_BITS; b++) begin : g_lane
    logic signed [DIFF_W-1:0] diff;
    logic signed [WIDE_W-1:0] diffWide;
    logic signed [WIDE_W-1:0] scaled;
    logic [LLR_W-1:0]         satVal;

    assign diff     = $signed({1'b0, min1Q[b]}) - $signed({1'b0, min0Q[b]});
    assign diffWide = WIDE_W'(diff);

    if (USE_MULT) begin : g_mult
      logic signed [WIDE_W-1:0] factor;
      logic signed [WIDE_W-1:0] prod;
      assign factor = $signed({{(WIDE_W-SCALE_W){1'b0}}, scaleQ});
      assign prod   = diffWide * factor;
      assign scaled = prod >>> FRAC_W;
    end else begin : g_shift
      assign scaled = diffWide >>> scaleQ;
    end

    always_comb begin
      if (scaled > SAT_HI)      satVal = SAT_HI[LLR_W-1:0];
      else if (scaled < SAT_LO) satVal = SAT_LO[LLR_W-1:0];
      else                      satVal = scaled[LLR_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)               llrOut[b*LLR_W +: LLR_W] <= '0;
      else if (strobes.capOut) llrOut[b*LLR_W +: LLR_W] <= satVal;
    end
  end
endmodule

// File: rtl/llr_unit.sv
module llr_unit #(
  parameter int METRIC_W = 10,
  parameter int SYM_BITS = 4,
  parameter int LLR_W    = 8,
  parameter int SCALE_W  = 4,
  parameter int FRAC_W   = 2,
  parameter bit USE_MULT = 1'b0
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [(1<<SYM_BITS)*METRIC_W-1:0] metricsIn,
  input  logic [SCALE_W-1:0]                scaleSel,
  output logic                              outValid,
  output logic [SYM_BITS*LLR_W-1:0]         llrOut
);
  llr_pkg::llrStrobes_t strobes;

  llr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  llr_datapath #(
    .METRIC_W (METRIC_W),
    .SYM_BITS (SYM_BITS),
    .LLR_W    (LLR_W),
    .SCALE_W  (SCALE_W),
    .FRAC_W   (FRAC_W),
    .USE_MULT (USE_MULT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .metricsIn (metricsIn),
    .scaleSel  (scaleSel),
    .llrOut    (llrOut)
  );
endmodule

// File: rtl/llr_unit_chk.sv
module llr_unit_chk #(
  parameter int METRIC_W = 10,
  parameter int SYM_BITS = 4,
  parameter int LLR_W    = 8,
  parameter int SCALE_W  = 4,
  parameter bit USE_MULT = 1'b0
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              inValid,
  input logic [(1<<SYM_BITS)*METRIC_W-1:0] metricsIn,
  input logic [SCALE_W-1:0]                scaleSel,
  input logic                              outValid,
  input logic [SYM_BITS*LLR_W-1:0]         llrOut
);
  localparam int NUM_PTS = 1 << SYM_BITS;

  logic [1:0] age;
  logic       allEqual;
  logic       lanesTiny;

  always_ff @(posedge clk) begin
    if (!rstN)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  always_comb begin
    allEqual = 1'b1;
    for (int p = 1; p < NUM_PTS; p++)
      if (metricsIn[p*METRIC_W +: METRIC_W] != metricsIn[METRIC_W-1:0]) allEqual = 1'b0;
    lanesTiny = 1'b1;
    for (int b = 0; b < SYM_BITS; b++)
      if (llrOut[b*LLR_W +: LLR_W] != '0 && llrOut[b*LLR_W +: LLR_W] != '1) lanesTiny = 1'b0;
  end

  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2) |-> (outValid == $past(inValid, 2)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && !outValid) |-> $stable(llrOut));

  assert_equal_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && outValid && $past(inValid && allEqual, 2)) |-> (llrOut == '0));

  assert_long_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!USE_MULT && age == 2'd2 && outValid && $past(int'(scaleSel) > METRIC_W, 2)) |-> lanesTiny);
endmodule

bind llr_unit llr_unit_chk #(
  .METRIC_W (METRIC_W),
  .SYM_BITS (SYM_BITS),
  .LLR_W    (LLR_W),
  .SCALE_W  (SCALE_W),
  .USE_MULT (USE_MULT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .metricsIn (metricsIn),
  .scaleSel  (scaleSel),
  .outValid  (outValid),
  .llrOut    (llrOut)
);

// File: tb/llr_unit_tb.sv
module llr_unit_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [159:0] metricsIn;
  logic [3:0]   scaleSel;
  logic         vShift, vMul;
  logic [31:0]  llrShift, llrMul;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  llr_unit #(.USE_MULT(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .metricsIn(metricsIn),
    .scaleSel(scaleSel), .outValid(vShift), .llrOut(llrShift));

  llr_unit #(.USE_MULT(1'b1)) u_dutMul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .metricsIn(metricsIn),
    .scaleSel(scaleSel), .outValid(vMul), .llrOut(llrMul));

  // Arithmetic reference for the four lanes (R2, R3, R4, R5, R7, R8).
  function automatic logic [31:0] refVec(input logic [159:0] m, input int k, input bit mul);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      int mn0, mn1, d, s;
      mn0 = 1 << 20;
      mn1 = 1 << 20;
      for (int p = 0; p < 16; p++) begin
        int v;
        v = int'(m[p*10 +: 10]);
        if (((p >> b) & 1) == 1) begin if (v < mn1) mn1 = v; end
        else begin if (v < mn0) mn0 = v; end
      end
      d = mn1 - mn0;
      if (mul) s = (d * k) >>> 2;
      else     s = d >>> k;
      if (s > 127) s = 127;
      if (s < -128) s = -128;
      r[b*8 +: 8] = 8'(s);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor model: two-stage expectation pipeline sampled at falling edges.
  bit          monOn = 1'b0;
  bit          expV [2];
  logic [31:0] expS [2];
  logic [31:0] expM [2];
  string       expT [2];
  logic [31:0] lastS = '0, lastM = '0;
  string       curTag = "R2";

  always @(negedge clk) begin
    if (monOn) begin
      check("R1 valid shift variant", {31'b0, vShift}, {31'b0, expV[1]});
      check("R1 valid mult variant",  {31'b0, vMul},   {31'b0, expV[1]});
      if (expV[1]) begin
        check({expT[1], " shift variant"}, llrShift, expS[1]);
        check({expT[1], " R8 mult variant"}, llrMul, expM[1]);
        lastS = expS[1];
        lastM = expM[1];
      end else begin
        check("R9 hold shift", llrShift, lastS);
        check("R9 hold mult",  llrMul,   lastM);
      end
      expV[1] = expV[0]; expS[1] = expS[0]; expM[1] = expM[0]; expT[1] = expT[0];
      expV[0] = inValid;
      expS[0] = refVec(metricsIn, int'(scaleSel), 1'b0);
      expM[0] = refVec(metricsIn, int'(scaleSel), 1'b1);
      expT[0] = curTag;
    end
  end

  task automatic drive(input logic [159:0] m, input int k, input bit v, input string tag);
    @(posedge clk);
    #2;
    metricsIn = m;
    scaleSel  = 4'(k);
    inValid   = v;
    curTag    = tag;
  endtask

  function automatic logic [159:0] fillAll(input int v);
    logic [159:0] r;
    for (int p = 0; p < 16; p++) r[p*10 +: 10] = 10'(v);
    return r;
  endfunction

  function automatic logic [159:0] randVec(input int hi);
    logic [159:0] r;
    for (int p = 0; p < 16; p++) r[p*10 +: 10] = 10'($urandom_range(hi, 0));
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [159:0] m;
    rstN = 1'b0; inValid = 1'b0; metricsIn = '0; scaleSel = '0;
    expV[0] = 0; expV[1] = 0; expS[0] = '0; expS[1] = '0; expM[0] = '0; expM[1] = '0;
    expT[0] = "R2"; expT[1] = "R2";
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset valid", {30'b0, vShift, vMul}, 32'h0);
    check("R9 reset llr shift", llrShift, 32'h0);
    check("R9 reset llr mult",  llrMul,   32'h0);
    @(posedge clk); #2;
    rstN  = 1'b1;
    monOn = 1'b1;

    // Single-point-hot: saturates toward the favoured bit value (R2, R5, R7).
    for (int p = 0; p < 16; p++) begin
      m = fillAll(1023);
      m[p*10 +: 10] = 10'd0;
      drive(m, 0, 1'b1, "R2 R5 R7 one-hot");
    end
    // Inverse: one point large, rest zero, so every lane is zero or saturated.
    for (int p = 0; p < 16; p++) begin
      m = fillAll(0);
      m[p*10 +: 10] = 10'd1023;
      drive(m, 4, 1'b1, "R2 R3 one-cold");
    end
    // Equal metrics give zero (R3).
    for (int v = 0; v < 1024; v += 127) drive(fillAll(v), v % 16, 1'b1, "R3 equal");
    // Scale sweep with small signed differences, floor rounding (R4).
    for (int k = 0; k < 16; k++) begin
      m = fillAll(500);
      m[1*10 +: 10] = 10'd495;
      m[2*10 +: 10] = 10'd507;
      m[0*10 +: 10] = 10'd498;
      drive(m, k, 1'b1, "R4 sweep");
    end
    // Back-to-back random stream (R6).
    for (int i = 0; i < 600; i++) drive(randVec(1023), i % 16, 1'b1, "R6 stream");
    // Narrow-range random to stay off the rails (R3, R4).
    for (int i = 0; i < 300; i++) drive(randVec(63), i % 6, 1'b1, "R3 R4 narrow");
    // Bubbles between vectors: valid timing and hold (R1, R9).
    for (int i = 0; i < 400; i++)
      drive(randVec(1023), $urandom_range(15, 0), bit'($urandom_range(1, 0)), "R1 R9 bubbles");
    for (int i = 0; i < 4; i++) drive(randVec(1023), 0, 1'b0, "R9 idle");
    @(posedge clk); #6;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule